// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a single timer channel with three software-visible registers: a control word, a compare limit and a live counter. When the run bit is set the counter steps up by one every clock. When the counter equals the compare limit, the block raises a one-cycle interrupt pulse. What follows the match depends on the repeat bit. With repeat clear, the timer clears its own run bit and stops, and the count stays at the limit. With repeat set, the count returns to zero and the timer keeps running, so it fires periodically.

Software drives three write strobes that share one data bus, and it reads the three registers back on dedicated outputs. A preload of the counter is clipped to the compare limit. Bus decoding, prescaling and interrupt routing belong to the surrounding system.

Top module: `cmp_uptimer`

## Requirements
- R1: After reset the control bits, the compare limit and the counter are all zero and `irq_o` is low.
- R2: A control write loads `wdata_i[0]` as the run bit and `wdata_i[1]` as the repeat bit. Both are visible on `ctrl_o` (bit 0 run, bit 1 repeat) on the cycle after the write. Clearing the run bit stops counting.
- R3: While running and not at the limit, the counter increases by exactly one per clock. While stopped, it holds its value.
- R4: When the counter equals the compare limit while running, `irq_o` is high for one cycle, on the cycle after that match.
- R5: On a match with the repeat bit clear, the run bit clears by itself and the counter stays at the limit.
- R6: On a match with the repeat bit set, the counter reads zero on the next cycle and the timer keeps running. The period is therefore limit+1 clocks.
- R7: A counter write loads the smaller of `wdata_i` and the compare limit held before that cycle.
- R8: A counter write made in the same cycle as a match takes priority over the wrap or hold of the count. The match still pulses `irq_o` and still applies its run-bit rule.
- R9: With a limit of zero and repeat set, `irq_o` is high on every running cycle. With repeat clear, it pulses once.
- R10: A control write made in the same cycle as a one-shot match takes priority over the automatic clearing of the run bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctrl_wr_i | input | 1 | Write strobe for the control bits |
| cmp_wr_i | input | 1 | Write strobe for the compare limit |
| cnt_wr_i | input | 1 | Write strobe for the counter preload |
| wdata_i | input | W | Write data shared by the three strobes |
| ctrl_o | output | 2 | Control readback: bit 0 run, bit 1 repeat |
| cmp_o | output | W | Compare limit readback |
| count_o | output | W | Live up-count |
| irq_o | output | 1 | One-cycle match pulse |

## Verification
The assertions assume that the write strobes and the data are stable across each rising edge and are low during reset. They also assume that a counter preload is compared against the limit already in place, not against a limit written in the same cycle. The bench drives all inputs on the falling edge and releases every strobe after one cycle. It never raises the compare strobe and the counter strobe together, so each check relates to a single, well-defined limit.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;

    localparam int RUN_BIT  = 0;
    localparam int REP_BIT  = 1;
    localparam int CTRL_W   = 2;

    typedef struct packed {
        logic rep;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/uptimer_clip.sv
module uptimer_clip #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] lim_i,
    output logic [W-1:0] val_o
);
    always_comb begin
        if (val_i > lim_i) val_o = lim_i;
        else               val_o = val_i;
    end
endmodule

// File: rtl/uptimer_regs.sv
module uptimer_regs
    import uptimer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_data_i,
    input  logic              cmp_wr_i,
    input  logic [W-1:0]      cmp_data_i,
    input  logic              hit_i,
    output ctrl_t             ctrl_o,
    output logic [W-1:0]      cmp_o
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] cmp;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_i && !st_q.ctrl.rep) st_d.ctrl.run = 1'b0;
        if (ctrl_wr_i) begin
            st_d.ctrl.run = ctrl_data_i[RUN_BIT];
            st_d.ctrl.rep = ctrl_data_i[REP_BIT];
        end
        if (cmp_wr_i) st_d.cmp = cmp_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign cmp_o  = st_q.cmp;

    // R5
    oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i && !ctrl_o.rep && !ctrl_wr_i |=> !ctrl_o.run);

    // R10
    ctrl_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr_i |=> ctrl_o == $past(ctrl_data_i));

    // R2
    cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmp_wr_i |=> $stable(cmp_o));
endmodule

// File: rtl/uptimer_count.sv
module uptimer_count #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         rep_i,
    input  logic [W-1:0] cmp_i,
    input  logic         cnt_wr_i,
    input  logic [W-1:0] cnt_data_i,
    output logic [W-1:0] count_o,
    output logic         hit_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] count;
        logic         irq;
    } cnt_t;

    cnt_t         st_d, st_q;
    logic [W-1:0] clipped;
    logic         hit;

    uptimer_clip #(.W(W)) i_clip (
        .val_i (cnt_data_i),
        .lim_i (cmp_i),
        .val_o (clipped)
    );

    always_comb begin
        st_d = st_q;
        hit  = run_i && (st_q.count == cmp_i);
        st_d.irq = hit;
        if (cnt_wr_i) begin
            st_d.count = clipped;
        end else if (hit) begin
            if (rep_i) st_d.count = '0;
        end else if (run_i) begin
            st_d.count = st_q.count + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign hit_o   = hit;
    assign irq_o   = st_q.irq;

    // R3
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && (count_o != cmp_i) && !cnt_wr_i |=> count_o == $past(count_o) + W'(1));

    // R3
    count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i && !cnt_wr_i |=> $stable(count_o));

    // R6
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && rep_i && (count_o == cmp_i) && !cnt_wr_i |=> count_o == '0);

    // R7
    clip_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_i |=> count_o <= $past(cmp_i));

    // R4
    irq_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(run_i));
endmodule

// File: rtl/cmp_uptimer.sv
module cmp_uptimer
    import uptimer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ctrl_wr_i,
    input  logic         cmp_wr_i,
    input  logic         cnt_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [1:0]   ctrl_o,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] count_o,
    output logic         irq_o
);
    ctrl_t        ctrl_q;
    logic [W-1:0] cmp_q;
    logic         hit;

    uptimer_regs #(.W(W)) i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctrl_wr_i   (ctrl_wr_i),
        .ctrl_data_i (wdata_i[CTRL_W-1:0]),
        .cmp_wr_i    (cmp_wr_i),
        .cmp_data_i  (wdata_i),
        .hit_i       (hit),
        .ctrl_o      (ctrl_q),
        .cmp_o       (cmp_q)
    );

    uptimer_count #(.W(W)) i_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (ctrl_q.run),
        .rep_i      (ctrl_q.rep),
        .cmp_i      (cmp_q),
        .cnt_wr_i   (cnt_wr_i),
        .cnt_data_i (wdata_i),
        .count_o    (count_o),
        .hit_o      (hit),
        .irq_o      (irq_o)
    );

    assign ctrl_o = ctrl_q;
    assign cmp_o  = cmp_q;

    // R4
    irq_at_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(count_o) == $past(cmp_o));
endmodule

// File: tb/test_cmp_uptimer.sv
`timescale 1ns/1ps
module test_cmp_uptimer;
    localparam int W = 16;
    localparam logic [1:0] OP_IDLE = 2'd0, OP_CTRL = 2'd1, OP_CMP = 2'd2, OP_CNT = 2'd3;
    localparam int NV = 18;

    // {op, data, exp count, exp ctrl, exp irq, requirement}
    localparam logic [40:0] VECS [0:NV-1] = '{
        {OP_CMP,  16'd5, 16'd0, 2'd0, 1'b0, 4'd7},  // R7
        {OP_CNT,  16'd3, 16'd3, 2'd0, 1'b0, 4'd7},
        {OP_CNT,  16'd9, 16'd5, 2'd0, 1'b0, 4'd7},
        {OP_CNT,  16'd0, 16'd0, 2'd0, 1'b0, 4'd7},
        {OP_CTRL, 16'd1, 16'd0, 2'd1, 1'b0, 4'd2},  // R2
        {OP_IDLE, 16'd0, 16'd1, 2'd1, 1'b0, 4'd3},  // R3
        {OP_IDLE, 16'd0, 16'd2, 2'd1, 1'b0, 4'd3},
        {OP_IDLE, 16'd0, 16'd3, 2'd1, 1'b0, 4'd3},
        {OP_IDLE, 16'd0, 16'd4, 2'd1, 1'b0, 4'd3},
        {OP_IDLE, 16'd0, 16'd5, 2'd1, 1'b0, 4'd3},
        {OP_IDLE, 16'd0, 16'd5, 2'd0, 1'b1, 4'd4},  // R4
        {OP_IDLE, 16'd0, 16'd5, 2'd0, 1'b0, 4'd5},  // R5
        {OP_CTRL, 16'd3, 16'd5, 2'd3, 1'b0, 4'd2},
        {OP_IDLE, 16'd0, 16'd0, 2'd3, 1'b1, 4'd6},  // R6
        {OP_IDLE, 16'd0, 16'd1, 2'd3, 1'b0, 4'd6},
        {OP_IDLE, 16'd0, 16'd2, 2'd3, 1'b0, 4'd6},
        {OP_CTRL, 16'd0, 16'd3, 2'd0, 1'b0, 4'd2},
        {OP_IDLE, 16'd0, 16'd3, 2'd0, 1'b0, 4'd3}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_wr = 1'b0, cmp_wr = 1'b0, cnt_wr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [1:0]   ctrl;
    logic [W-1:0] cmp, count;
    logic         irq;
    int           total = 0;
    int           bad = 0;
    bit           finished = 1'b0;

    always #2.5 clk = ~clk;

    cmp_uptimer #(.W(W)) i_cmp_uptimer (
        .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .cmp_wr_i(cmp_wr),
        .cnt_wr_i(cnt_wr), .wdata_i(wdata), .ctrl_o(ctrl), .cmp_o(cmp),
        .count_o(count), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [1:0] op, input logic [W-1:0] d);
        wdata   = d;
        ctrl_wr = (op == OP_CTRL);
        cmp_wr  = (op == OP_CMP);
        cnt_wr  = (op == OP_CNT);
        @(negedge clk);
        ctrl_wr = 1'b0; cmp_wr = 1'b0; cnt_wr = 1'b0; wdata = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ones;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 ctrl", ctrl, 0);
        chk("R1 cmp", cmp, 0);
        chk("R1 count", count, 0);
        chk("R1 irq", irq, 0);

        for (int i = 0; i < NV; i++) begin
            logic [40:0] v;
            string tag;
            v = VECS[i];
            step(v[40:39], v[38:23]);
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            chk({tag, " count"}, count, v[22:7]);
            chk({tag, " ctrl"}, ctrl, v[6:5]);
            chk({tag, " irq"}, irq, v[4]);
        end

        // R8: preload lands in the same cycle as a one-shot match
        step(OP_CMP, 16'd4);
        step(OP_CNT, 16'd4);
        step(OP_CTRL, 16'd1);
        step(OP_CNT, 16'd1);
        chk("R8 count", count, 1);
        chk("R8 irq", irq, 1);
        chk("R8 ctrl", ctrl, 0);

        // R10: control write on the match cycle keeps the run bit
        step(OP_CNT, 16'd4);
        step(OP_CTRL, 16'd1);
        step(OP_CTRL, 16'd1);
        chk("R10 ctrl", ctrl, 1);
        chk("R10 irq", irq, 1);
        chk("R10 count", count, 4);
        step(OP_IDLE, 16'd0);
        chk("R5 ctrl", ctrl, 0);
        chk("R5 irq", irq, 1);

        // R9: zero limit
        step(OP_CMP, 16'd0);
        step(OP_CNT, 16'd0);
        step(OP_CTRL, 16'd3);
        ones = 0;
        for (int k = 0; k < 6; k++) begin
            step(OP_IDLE, 16'd0);
            if (irq) ones++;
        end
        chk("R9 repeat pulses", ones, 6);
        chk("R9 repeat count", count, 0);
        step(OP_CTRL, 16'd0);
        step(OP_CTRL, 16'd1);
        ones = 0;
        for (int k = 0; k < 4; k++) begin
            step(OP_IDLE, 16'd0);
            if (irq) ones++;
        end
        chk("R9 oneshot pulses", ones, 1);
        chk("R9 oneshot ctrl", ctrl, 0);

        // R6: period is limit+1
        step(OP_CMP, 16'd3);
        step(OP_CNT, 16'd0);
        step(OP_CTRL, 16'd3);
        ones = 0;
        for (int k = 0; k < 40; k++) begin
            step(OP_IDLE, 16'd0);
            if (irq) ones++;
        end
        chk("R6 pulses in 40", ones, 10);
        chk("R6 count", count, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule